// File: doc/BRIEF.md
# Peripheral Request Router and Channel Arbiter

This block sits between a large set of peripheral DMA request lines and a smaller pool of DMA channels. A small register-mapped table holds one routing entry per request line. Each entry says whether the line is routed at all and to which channel. A channel's request output rises when its run input is set and at least one routed line aimed at it is asserted. Several lines may share one channel, and their requests are then ORed.

A registered arbiter picks one channel at a time to serve. Channels sit in four fixed priority tiers, chosen by bits 3:2 of the channel index, so tier 0 holds channels 0-3 and 16-19. Within a tier, a rotating pointer shares service fairly. A grant is never pre-empted: it lasts until the served channel drops its request or reports that its burst is done. The next choice is made at that same clock edge.

Top module: `reqmap_arbiter`

## Requirements
- R1: The routing entry for request line n is written at byte address 0x0100 + 4*n for n < 64, and at 0x1100 + 4*(n mod 64) for n >= 64. A write to any other address, including a misaligned one, changes no entry.
- R2: Entry field layout: write-data bit 7 is the route-valid flag and bits 4:0 are the target channel number. All other data bits are ignored. Writing zero removes the route.
- R3: chan_req[c] is 1 exactly when chan_run[c] is 1 and some line with a valid entry naming channel c is asserted. Lines that share a channel are ORed.
- R4: The priority tier of channel c is (c & 15) >> 2, and tier 0 is the highest. When the arbiter picks a new grant, it picks from the highest tier that has a requesting channel.
- R5: Within a tier, the pick is the first requesting channel after the last channel granted in that tier, in ascending index order with wrap-around. After reset, each tier starts its search at index 0.
- R6: While the granted channel keeps chan_req high and burst_done is low, the grant does not change, even if a higher tier requests.
- R7: When the granted channel drops its request, or burst_done is high, or no grant is held, the arbiter issues a fresh pick. It appears on the outputs one clock edge later. If nothing is requesting, grant_valid goes low.
- R8: grant_oh has exactly bit grant_idx set while grant_valid is 1. It is all zeros, and grant_idx is 0, while grant_valid is 0.
- R9: After reset, every entry is invalid and no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (16) | Register byte address |
| wr_data | input | DATA_W (32) | Register write data |
| req_lines | input | N_REQ (64) | Peripheral request lines |
| chan_run | input | N_CH (32) | Per-channel run enable |
| burst_done | input | 1 | Served channel finished its burst |
| chan_req | output | N_CH (32) | Routed, run-gated per-channel requests |
| grant_valid | output | 1 | A channel is granted |
| grant_idx | output | CH_W (5) | Index of the granted channel |
| grant_oh | output | N_CH (32) | One-hot grant |

## Verification
On every cycle, the bound checker checks four things:
- run gating of the channel requests;
- the one-hot shape of the grant and its agreement with the index;
- that a held grant stays put while its channel requests without burst_done;
- that an idle arbiter facing a request grants on the next edge.

Other behaviours can only be shown by the bench's scenarios, because they depend on history and on the table contents:
- address decoding and field ignoring;
- route removal;
- ORing of shared channels;
- tier ordering;
- the exact rotation order inside a tier.

// File: rtl/reqmap_pkg.sv
package reqmap_pkg;
   localparam int VLD_BIT   = 7;
   localparam int CHSEL_W   = 5;
   localparam int NUM_TIER  = 4;
   localparam int LO_BASE   = 'h0100;
   localparam int HI_BASE   = 'h1100;

   typedef struct packed {
      logic               vld;
      logic [CHSEL_W-1:0] ch;
   } route_t;

   function automatic int tier_of(input int c);
      return (c & 15) >> 2;
   endfunction

   function automatic int entry_addr(input int n);
      return (n < 64) ? (LO_BASE + 4 * n) : (HI_BASE + 4 * (n % 64));
   endfunction
endpackage

// File: rtl/route_table.sv
module route_table
   import reqmap_pkg::*;
#(
   parameter int N_REQ  = 64,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   output route_t [N_REQ-1:0]      routes
);
   generate
      for (genvar n = 0; n < N_REQ; n++) begin : g_entry
         localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(entry_addr(n));
         route_t ent_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               ent_q <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
               ent_q <= route_t'({wr_data[VLD_BIT], wr_data[CHSEL_W-1:0]});
         end
         assign routes[n] = ent_q;
      end
   endgenerate
endmodule

// File: rtl/req_router.sv
module req_router
   import reqmap_pkg::*;
#(
   parameter int N_REQ = 64,
   parameter int N_CH  = 32
) (
   input  logic [N_REQ-1:0]   req_lines,
   input  route_t [N_REQ-1:0] routes,
   input  logic [N_CH-1:0]    chan_run,
   output logic [N_CH-1:0]    chan_req
);
   always_comb begin
      for (int c = 0; c < N_CH; c++) begin
         logic hit;
         hit = 1'b0;
         for (int n = 0; n < N_REQ; n++) begin
            if (routes[n].vld && routes[n].ch == CHSEL_W'(c) && req_lines[n])
               hit = 1'b1;
         end
         chan_req[c] = hit & chan_run[c];
      end
   end
endmodule

// File: rtl/tier_arbiter.sv
module tier_arbiter
   import reqmap_pkg::*;
#(
   parameter int N_CH = 32,
   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] chan_req,
   input  logic            burst_done,
   output logic            grant_valid,
   output logic [CH_W-1:0] grant_idx,
   output logic [N_CH-1:0] grant_oh
);
   logic [CH_W-1:0] last_q [NUM_TIER];
   logic            gnt_vld_q;
   logic [CH_W-1:0] gnt_idx_q;
   logic            pick_any;
   logic [CH_W-1:0] pick_idx;
   logic [1:0]      pick_tier;
   logic            hold;

   always_comb begin
      logic            found;
      logic [CH_W-1:0] cand;
      pick_any = 1'b0;
      pick_idx = '0;
      for (int g = NUM_TIER - 1; g >= 0; g--) begin
         found = 1'b0;
         cand  = '0;
         for (int k = 1; k <= N_CH; k++) begin
            int c;
            c = (int'(last_q[g]) + k) % N_CH;
            if (!found && tier_of(c) == g && chan_req[c]) begin
               found = 1'b1;
               cand  = CH_W'(c);
            end
         end
         if (found) begin
            pick_any = 1'b1;
            pick_idx = cand;
         end
      end
   end

   assign pick_tier = 2'(tier_of(int'(pick_idx)));
   assign hold      = gnt_vld_q & chan_req[gnt_idx_q] & ~burst_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_vld_q <= 1'b0;
         gnt_idx_q <= '0;
         for (int g = 0; g < NUM_TIER; g++) last_q[g] <= CH_W'(N_CH - 1);
      end else if (!hold) begin
         gnt_vld_q <= pick_any;
         gnt_idx_q <= pick_any ? pick_idx : '0;
         if (pick_any) last_q[pick_tier] <= pick_idx;
      end
   end

   assign grant_valid = gnt_vld_q;
   assign grant_idx   = gnt_idx_q;
   assign grant_oh    = gnt_vld_q ? (N_CH'(1) << gnt_idx_q) : '0;
endmodule

// File: rtl/reqmap_arbiter.sv
module reqmap_arbiter
   import reqmap_pkg::*;
#(
   parameter int N_REQ  = 64,
   parameter int N_CH   = 32,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [N_REQ-1:0]  req_lines,
   input  logic [N_CH-1:0]   chan_run,
   input  logic              burst_done,
   output logic [N_CH-1:0]   chan_req,
   output logic              grant_valid,
   output logic [CH_W-1:0]   grant_idx,
   output logic [N_CH-1:0]   grant_oh
);
   generate
      if (N_REQ < 1 || N_REQ > 128) begin : g_bad_req
         $error("N_REQ must lie in 1..128");
      end
      if (N_CH < 2 || N_CH > (1 << CHSEL_W)) begin : g_bad_ch
         $error("N_CH must lie in 2..32");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (ADDR_W < 13 || (1 << ADDR_W) <= entry_addr(N_REQ - 1)) begin : g_bad_addr
         $error("ADDR_W too narrow for entry addresses");
      end
   endgenerate

   route_t [N_REQ-1:0] routes;

   route_table #(.N_REQ(N_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .routes(routes)
   );

   req_router #(.N_REQ(N_REQ), .N_CH(N_CH)) u_router (
      .req_lines(req_lines), .routes(routes), .chan_run(chan_run),
      .chan_req(chan_req)
   );

   tier_arbiter #(.N_CH(N_CH)) u_arb (
      .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .burst_done(burst_done),
      .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_oh(grant_oh)
   );
endmodule

// File: rtl/reqmap_arbiter_chk.sv
module reqmap_arbiter_chk #(
   parameter int N_CH = 32,
   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] chan_run,
   input logic [N_CH-1:0] chan_req,
   input logic            burst_done,
   input logic            grant_valid,
   input logic [CH_W-1:0] grant_idx,
   input logic [N_CH-1:0] grant_oh
);
   p_run_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_req & ~chan_run) == '0);

   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_oh) && (grant_valid == (|grant_oh)));

   p_idx_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> grant_oh[grant_idx]);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && chan_req[grant_idx] && !burst_done)
      |=> (grant_valid && grant_idx == $past(grant_idx)));

   p_idle_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid && (|chan_req)) |=> grant_valid);
endmodule

bind reqmap_arbiter reqmap_arbiter_chk #(.N_CH(N_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_run(chan_run), .chan_req(chan_req),
   .burst_done(burst_done), .grant_valid(grant_valid),
   .grant_idx(grant_idx), .grant_oh(grant_oh)
);

// File: tb/reqmap_arbiter_tb.sv
module reqmap_arbiter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N_REQ = 64;
   localparam int N_CH  = 32;
   localparam int NVEC  = 8;

   localparam logic [63:0] V_REQ [0:NVEC-1] = '{
      64'h1, 64'h4, 64'h2, 64'h8, 64'h1,
      64'h8000_0000_0000_0400, 64'hB, 64'h0090_0000 };
   localparam logic [31:0] V_RUN [0:NVEC-1] = '{
      32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
      32'hFFFF_FFDF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_EFFF };
   localparam logic [31:0] V_EXP [0:NVEC-1] = '{
      32'h20, 32'h20, 32'h0002_0000, 32'h0, 32'h0,
      32'h8000_0001, 32'h0002_0020, 32'h10 };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [N_REQ-1:0] req_lines = '0;
   logic [N_CH-1:0]  chan_run = '1;
   logic        burst_done = 1'b0;
   logic [N_CH-1:0] chan_req;
   logic        grant_valid;
   logic [4:0]  grant_idx;
   logic [N_CH-1:0] grant_oh;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   reqmap_arbiter #(.N_REQ(N_REQ), .N_CH(N_CH)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .req_lines(req_lines), .chan_run(chan_run),
      .burst_done(burst_done), .chan_req(chan_req), .grant_valid(grant_valid),
      .grant_idx(grant_idx), .grant_oh(grant_oh)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_gnt(input string tag, input int idx);
      chk({tag, " valid"}, 64'(grant_valid), 64'd1);
      chk({tag, " idx"}, 64'(grant_idx), 64'(idx));
      chk({tag, " onehot"}, 64'(grant_oh), 64'(32'h1 << idx));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      wr_en = 1'b1; wr_addr = 16'(addr); wr_data = data;
      step();
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      req_lines = '1;
      #1;
      // R9: no routes after reset, no grant
      chk("R9 chan_req", 64'(chan_req), 64'h0);
      chk("R9 grant_valid", 64'(grant_valid), 64'h0);
      chk("R9 grant_oh", 64'(grant_oh), 64'h0);
      req_lines = '0;

      wr('h100 + 4*0,  32'h85);
      wr('h100 + 4*1,  32'h91);
      wr('h100 + 4*2,  32'h85);
      wr('h100 + 4*3,  32'h09);        // valid flag clear
      wr('h100 + 4*10, 32'h80);
      wr('h100 + 4*20, 32'h84);
      wr('h100 + 4*21, 32'h90);
      wr('h100 + 4*22, 32'h81);
      wr('h100 + 4*23, 32'h8C);
      wr('h100 + 4*24, 32'h82);
      wr('h100 + 4*63, 32'hFFFF_FFFF); // junk bits ignored -> ch 31

      // R3/R2 routing table walk
      for (int i = 0; i < NVEC; i++) begin
         req_lines = V_REQ[i];
         chan_run  = V_RUN[i];
         #1;
         chk($sformatf("R3 vec%0d chan_req", i), 64'(chan_req), 64'(V_EXP[i]));
         @(negedge clk);
      end
      req_lines = '0; chan_run = '1;
      step(); step();
      chk("R7 idle", 64'(grant_valid), 64'h0);

      // R4 tier order: ch4 (tier1) beats ch12 (tier3)
      req_lines[20] = 1'b1; req_lines[23] = 1'b1;
      step(); chk_gnt("R4 tier", 4);
      // R6 hold despite tier0 request
      req_lines[21] = 1'b1;
      step(); chk_gnt("R6 hold", 4);
      // R7 burst_done release -> ch16
      burst_done = 1'b1;
      step(); chk_gnt("R7 burst release", 16);
      burst_done = 1'b0;
      // R5 rotation after 16 wraps to 0
      req_lines[10] = 1'b1; req_lines[22] = 1'b1; req_lines[24] = 1'b1;
      req_lines[21] = 1'b0;
      step(); chk_gnt("R5 wrap", 0);
      req_lines[10] = 1'b0;
      step(); chk_gnt("R7 drop release", 1);
      req_lines[22] = 1'b0;
      step(); chk_gnt("R5 next", 2);
      req_lines[24] = 1'b0;
      step(); chk_gnt("R4 fall to tier1", 4);
      req_lines[10] = 1'b1; req_lines[22] = 1'b1;
      step(); chk_gnt("R6 no preempt", 4);
      burst_done = 1'b1;
      step(); chk_gnt("R5 after ptr2", 0);
      step(); chk_gnt("R5 rotate", 1);
      step(); chk_gnt("R5 rotate back", 0);
      burst_done = 1'b0;
      // R3 run gating releases ch0
      chan_run[0] = 1'b0;
      step();
      chk("R3 gated ch0", 64'(chan_req[0]), 64'h0);
      chk_gnt("R7 gated release", 1);
      req_lines = '0; chan_run = '1;
      step();
      chk("R8 idle valid", 64'(grant_valid), 64'h0);
      chk("R8 idle oh", 64'(grant_oh), 64'h0);
      chk("R8 idle idx", 64'(grant_idx), 64'h0);

      // R2 removal, R1 decode of bad addresses
      wr('h100, 32'h0);
      wr('h1100, 32'h86);
      wr('h105, 32'h80);
      req_lines = 64'h1;
      #1 chk("R2 removed line0", 64'(chan_req), 64'h0);
      req_lines = 64'h4;
      #1 chk("R1 line2 intact", 64'(chan_req), 64'h20);
      req_lines = 64'h2;
      #1 chk("R1 misaligned ignored", 64'(chan_req), 64'h0002_0000);
      req_lines = '0;
      step();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule